// File: doc/BRIEF.md
# Supply-switch request and acknowledge registers

This block is the software-facing side of a card controller's supply switching. The controller raises single-cycle request pulses when it wants the card bus powered off or on, or the IO signalling level moved low or high. Each pulse latches a sticky status bit. A mask register chooses which latched requests drive a level interrupt. Software reads the status word, clears the bits it has handled with a write-one-to-clear register, and reports the outcome by writing an acknowledge register.

The acknowledge register carries two success bits, one for the bus-power class (on or off) and one for the IO-level class (low or high). Writing it sends single-cycle success pulses back to the requesting logic and leaves nothing stored. All access goes through a 32-bit word-addressed register port with a write strobe and a combinational read path.

Top module: `pwr_sw_regs`

## Requirements
- R1: After reset every register reads zero, and `irq_o`, `ack_bus_o` and `ack_io_o` are low.
- R2: A high `req_i` bit in a cycle sets the matching status bit, visible from the next cycle. The bit map is: bit 0 bus off, bit 1 bus on, bit 2 IO low, bit 3 IO high. Several bits may be set in the same cycle.
- R3: A status bit stays set until it is cleared through the clear register.
- R4: Writing the clear register (word address 0x39) clears exactly the status bits written as 1 in `wdata_i[3:0]`; the other bits keep their value.
- R5: When a request pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R6: The mask register (word address 0x38) holds `wdata_i[3:0]` and reads back in bits 3:0. `irq_o` is high exactly while some status bit and its mask bit are both set.
- R7: A write to the acknowledge register (word address 0x3A) drives `ack_bus_o` high for exactly the next cycle when `wdata_i[0]` is 1, and `ack_io_o` high for exactly the next cycle when `wdata_i[2]` is 1. Other data bits have no effect.
- R8: Reads of the clear register, the acknowledge register and every unmapped word address return zero.
- R9: The status register (word address 0x37) is read-only. Writes to it, and writes to unmapped addresses, change no register.
- R10: Bits 31:4 written to the mask register are discarded and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Request pulses: bus off, bus on, IO low, IO high |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt from the masked status bits |
| ack_bus_o | output | 1 | Bus-power success pulse |
| ack_io_o | output | 1 | IO-level success pulse |

## Verification
The bench puts a request and a clear of the same bit in one cycle. A design where the clear wins would lose the request and read zero. It also clears a partial mask over several pending bits, which exposes a clear register that wipes the whole word or ignores some bits. Acknowledge writes are checked on every cycle, including data with only the unused bits set: an acknowledge that lasts two cycles or fires on the wrong bit shows up as a mismatch on the pulse pins. Writes to the read-only status word and to unmapped words, and wide mask writes, would otherwise show as corrupted status, mask or interrupt values.

// File: rtl/pwr_sw_pkg.sv
package pwr_sw_pkg;
  // Word indices of the registers (byte offset divided by four).
  localparam int unsigned WORD_STATUS = 32'hDC >> 2;
  localparam int unsigned WORD_MASK   = 32'hE0 >> 2;
  localparam int unsigned WORD_CLEAR  = 32'hE4 >> 2;
  localparam int unsigned WORD_ACK    = 32'hE8 >> 2;

  // Request bit positions in the status, mask and clear words.
  localparam int unsigned REQ_BUS_OFF = 0;
  localparam int unsigned REQ_BUS_ON  = 1;
  localparam int unsigned REQ_IO_LOW  = 2;
  localparam int unsigned REQ_IO_HIGH = 3;

  // Success bit positions in the acknowledge word.
  localparam int unsigned ACK_BUS_BIT = 0;
  localparam int unsigned ACK_IO_BIT  = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_CLEAR,
    SEL_ACK
  } reg_sel_e;
endpackage

// File: rtl/pwr_sw_rst_sync.sv
module pwr_sw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pwr_sw_decode.sv
module pwr_sw_decode
  import pwr_sw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(WORD_STATUS)) sel_o = SEL_STATUS;
    if (addr_i == ADDR_W'(WORD_MASK))   sel_o = SEL_MASK;
    if (addr_i == ADDR_W'(WORD_CLEAR))  sel_o = SEL_CLEAR;
    if (addr_i == ADDR_W'(WORD_ACK))    sel_o = SEL_ACK;
  end
endmodule

// File: rtl/pwr_sw_status.sv
module pwr_sw_status #(
  parameter int unsigned NREQ = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] req_i,
  input  logic            clr_en_i,
  input  logic [NREQ-1:0] clr_bits_i,
  input  logic            mask_we_i,
  input  logic [NREQ-1:0] mask_wdata_i,
  output logic [NREQ-1:0] status_o,
  output logic [NREQ-1:0] mask_o,
  output logic            irq_o
);
  logic [NREQ-1:0] status_q, status_d;
  logic [NREQ-1:0] mask_q, mask_d;
  logic            status_en;

  // Per bit: a request sets, a clear drops, and a request beats a clear.
  for (genvar i = 0; i < NREQ; i++) begin : g_bit
    assign status_d[i] = req_i[i] | (status_q[i] & ~(clr_en_i & clr_bits_i[i]));
  end

  always_comb begin
    status_en = (|req_i) | clr_en_i;
    mask_d    = mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);
endmodule

// File: rtl/pwr_sw_ack.sv
module pwr_sw_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_we_i,
  input  logic bus_ok_i,
  input  logic io_ok_i,
  output logic ack_bus_o,
  output logic ack_io_o
);
  logic [1:0] pulse_q, pulse_d;

  // Nothing is held: the register holds a pulse for one cycle and then returns to zero.
  always_comb begin
    pulse_d = '0;
    if (ack_we_i) begin
      pulse_d = {io_ok_i, bus_ok_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
    end else begin
      pulse_q <= pulse_d;
    end
  end

  assign ack_bus_o = pulse_q[0];
  assign ack_io_o  = pulse_q[1];
endmodule

// File: rtl/pwr_sw_regs.sv
module pwr_sw_regs
  import pwr_sw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREQ   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NREQ-1:0]   req_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              ack_bus_o,
  output logic              ack_io_o
);
  localparam int unsigned SPARE_W = DATA_W - NREQ;

  logic            rst_s;
  reg_sel_e        sel;
  logic [NREQ-1:0] status_q;
  logic [NREQ-1:0] mask_q;
  logic            clr_en, mask_we, ack_we;
  logic            unused_wdata;

  pwr_sw_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_s)
  );

  pwr_sw_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  always_comb begin
    clr_en  = wr_en_i && (sel == SEL_CLEAR);
    mask_we = wr_en_i && (sel == SEL_MASK);
    ack_we  = wr_en_i && (sel == SEL_ACK);
  end

  pwr_sw_status #(.NREQ(NREQ)) u_stat (
    .clk_i        (clk_i),
    .rst_ni       (rst_s),
    .req_i        (req_i),
    .clr_en_i     (clr_en),
    .clr_bits_i   (wdata_i[NREQ-1:0]),
    .mask_we_i    (mask_we),
    .mask_wdata_i (wdata_i[NREQ-1:0]),
    .status_o     (status_q),
    .mask_o       (mask_q),
    .irq_o        (irq_o)
  );

  pwr_sw_ack u_ack (
    .clk_i     (clk_i),
    .rst_ni    (rst_s),
    .ack_we_i  (ack_we),
    .bus_ok_i  (wdata_i[ACK_BUS_BIT]),
    .io_ok_i   (wdata_i[ACK_IO_BIT]),
    .ack_bus_o (ack_bus_o),
    .ack_io_o  (ack_io_o)
  );

  // Clear and acknowledge are write-only and read as zero.
  always_comb begin
    unique case (sel)
      SEL_STATUS: rdata_o = {{SPARE_W{1'b0}}, status_q};
      SEL_MASK:   rdata_o = {{SPARE_W{1'b0}}, mask_q};
      default:    rdata_o = '0;
    endcase
  end

  assign unused_wdata = &{1'b0, wdata_i[DATA_W-1:NREQ]};
endmodule

// File: rtl/pwr_sw_regs_chk.sv
module pwr_sw_regs_chk
  import pwr_sw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NREQ   = 4
) (
  input logic              clk_i,
  input logic              rst_s,
  input logic [NREQ-1:0]   req_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NREQ-1:0]   status_q,
  input logic [NREQ-1:0]   mask_q,
  input logic              irq_o,
  input logic              ack_bus_o,
  input logic              ack_io_o
);
  // R2
  req_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (req_i != '0) |=> ((status_q & $past(req_i)) == $past(req_i)));

  // R3
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    !(wr_en_i && addr_i == ADDR_W'(WORD_CLEAR)) |=>
      ((status_q & $past(status_q)) == $past(status_q)));

  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (wr_en_i && addr_i == ADDR_W'(WORD_CLEAR)) |=>
      ((status_q & $past(wdata_i[NREQ-1:0]) & ~$past(req_i)) == '0));

  // R6
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    (mask_q == '0) |-> !irq_o);

  // R7
  ack_bus_src_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    ack_bus_o |-> $past(wr_en_i && addr_i == ADDR_W'(WORD_ACK) && wdata_i[ACK_BUS_BIT]));

  // R7
  ack_io_src_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    ack_io_o |-> $past(wr_en_i && addr_i == ADDR_W'(WORD_ACK) && wdata_i[ACK_IO_BIT]));
endmodule

bind pwr_sw_regs pwr_sw_regs_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NREQ   (NREQ)
) u_chk (
  .clk_i     (clk_i),
  .rst_s     (rst_s),
  .req_i     (req_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .irq_o     (irq_o),
  .ack_bus_o (ack_bus_o),
  .ack_io_o  (ack_io_o)
);

// File: tb/tb_pwr_sw_regs.sv
module tb_pwr_sw_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_STAT = 6'h37;
  localparam logic [5:0] A_MASK = 6'h38;
  localparam logic [5:0] A_CLR  = 6'h39;
  localparam logic [5:0] A_ACK  = 6'h3A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req;
  logic        wr_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, ack_bus, ack_io;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit compare_on = 0;

  // Reference model state
  int m_status = 0;
  int m_mask = 0;
  bit m_ack_bus = 0;
  bit m_ack_io = 0;

  pwr_sw_regs dut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .wr_en_i (wr_en),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq),
    .ack_bus_o (ack_bus), .ack_io_o (ack_io)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_status = 0; m_mask = 0; m_ack_bus = 0; m_ack_io = 0;
    end else begin
      int kept;
      kept = m_status;
      if (wr_en && addr == A_CLR) kept = kept & ~int'(wdata[3:0]);
      m_status = (kept | int'(req)) & 'hF;
      if (wr_en && addr == A_MASK) m_mask = int'(wdata[3:0]);
      m_ack_bus = wr_en && addr == A_ACK && wdata[0];
      m_ack_io  = wr_en && addr == A_ACK && wdata[2];
    end
  end

  // R6 R7: compared every cycle against the model
  always @(negedge clk) begin
    if (compare_on) begin
      check("R6 irq", irq, (m_status & m_mask) != 0);
      check("R7 ack_bus", ack_bus, m_ack_bus);
      check("R7 ack_io", ack_io, m_ack_io);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic w, input logic [5:0] a, input logic [31:0] d,
                      input logic [3:0] r);
    wr_en = w; addr = a; wdata = d; req = r;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; req = '0;
  endtask

  task automatic rd(input logic [5:0] a, input longint exp, input string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    compare_on = 1;

    // R1 reset state
    rd(A_STAT, 0, "R1 status");
    rd(A_MASK, 0, "R1 mask");
    check("R1 irq", irq, 0);
    check("R1 ack", {ack_bus, ack_io}, 0);

    // R2 single request, R3 sticky
    step(0, 0, 0, 4'b0010);
    rd(A_STAT, 2, "R2 bus-on sets bit1");
    step(0, 0, 0, 0); step(0, 0, 0, 0);
    rd(A_STAT, 2, "R3 still set");

    // R6 mask, R10 wide mask write
    check("R6 irq off unmasked", irq, 0);
    step(1, A_MASK, 32'h2, 0);
    check("R6 irq on", irq, 1);
    rd(A_MASK, 2, "R6 mask readback");
    step(1, A_MASK, 32'hFFFF_FFF4, 0);
    rd(A_MASK, 4, "R10 upper mask bits dropped");
    check("R6 irq off other bit", irq, 0);

    // R4 clear
    step(1, A_CLR, 32'h2, 0);
    rd(A_STAT, 0, "R4 clear bit1");
    step(0, 0, 0, 4'b1101);
    rd(A_STAT, 'hD, "R2 multiple requests");
    check("R6 irq io-low masked in", irq, 1);
    step(1, A_CLR, 32'h5, 0);
    rd(A_STAT, 8, "R4 partial clear");

    // R5 request beats clear on same bit
    step(1, A_CLR, 32'h8, 4'b1000);
    rd(A_STAT, 8, "R5 set wins");
    step(1, A_CLR, 32'hF, 0);
    rd(A_STAT, 0, "R4 clear all");

    // R9 read-only status, unmapped write
    step(1, A_STAT, 32'hF, 0);
    rd(A_STAT, 0, "R9 status write ignored");
    step(1, 6'h00, 32'hF, 0);
    rd(A_MASK, 4, "R9 unmapped write ignored");
    rd(A_STAT, 0, "R9 unmapped write status");

    // R7 acknowledge pulses
    step(1, A_ACK, 32'h5, 0);
    check("R7 both pulses", {ack_io, ack_bus}, 2'b11);
    step(0, 0, 0, 0);
    check("R7 pulses end", {ack_io, ack_bus}, 2'b00);
    step(1, A_ACK, 32'h1, 0);
    check("R7 bus only", {ack_io, ack_bus}, 2'b01);
    step(1, A_ACK, 32'h4, 0);
    check("R7 io only", {ack_io, ack_bus}, 2'b10);
    step(1, A_ACK, 32'hFFFF_FFFA, 0);
    check("R7 other bits ignored", {ack_io, ack_bus}, 2'b00);

    // R8 write-only and unmapped reads
    rd(A_CLR, 0, "R8 clear reads zero");
    rd(A_ACK, 0, "R8 ack reads zero");
    rd(6'h00, 0, "R8 unmapped low");
    rd(6'h3F, 0, "R8 unmapped high");

    step(0, 0, 0, 0);
    compare_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule